// File: doc/BRIEF.md
# Eight-pin GPIO port with change notification

This block is one slice of a general-purpose I/O port. Each of its pins is set as an input or an output by a direction register. An output pin drives the value held in an output latch. A separate mask marks pins as analog, and those pins always read back as zero. External pin levels pass through a two-flop synchronizer. The result is registered once more before software sees it, so a port read shows a latch write or a direction change one cycle late.

A change detector compares every synchronized pin with its value one cycle earlier. A difference on a pin that is enabled for notification and not marked analog sets a sticky flag, which drives the interrupt request. Software clears the flag by writing 1 to bit 0 of the flag register. Each pin also has a pull-up enable bit. The pull-up output is forced off on any pin that is set as an output.

Top module: `gpio_cn_port`

## Requirements
- R1: After reset the direction register (address 0) reads all ones, so every pin is an input. The latch (1), analog mask (2), notify-enable (3) and pull-up (4) registers read zero, the flag register (6) reads zero, `irq` is low and `pin_oe` is zero.
- R2: A direction bit of 1 makes the pin an input and a bit of 0 makes it an output. `pin_oe` bit i is the inverse of direction bit i, and `pin_out` always carries the latch. A read of the pin register (address 5) returns the latch bit for output pins and the synchronized external level for input pins.
- R3: A pin register read in the cycle right after a latch or direction write returns the old value. The read one cycle later returns the new value. An external level change appears in a pin register read three clock edges after it is applied.
- R4: Any pin whose analog mask bit is 1 reads as 0 in the pin register, whatever its level.
- R5: `pullup_en` bit i equals pull-up register bit i ANDed with direction bit i, so it is never 1 on an output pin.
- R6: When a synchronized input differs from its value in the previous cycle, and that pin's notify-enable bit is 1 and its analog bit is 0, the flag is set and `irq` rises on the third clock edge after the level change.
- R7: The flag is sticky. It stays set until a write to address 6 with data bit 0 set, and it reads back as bit 0 of address 6.
- R8: A level change on a pin with notify-enable 0, or with its analog bit 1, never sets the flag.
- R9: If a clear write and a new qualifying change fall in the same cycle, the flag remains set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for the selected register (combinational) |
| pin_in | input | NPINS | External pin levels (asynchronous) |
| pin_out | output | NPINS | Output latch driven toward the pads |
| pin_oe | output | NPINS | Output enable per pin (1 = drive) |
| pullup_en | output | NPINS | Effective pull-up enable per pin |
| irq | output | 1 | Change-notification interrupt request (sticky flag) |

## Verification
The assertions assume that the bus is only driven with defined addresses and that `pin_in` carries no X. They also assume that any pin edge the change check relies on is held for at least two cycles, so it passes cleanly through the synchronizer. The stimulus changes `pin_in` only on falling clock edges and holds each level for several cycles. It changes only one enabled pin at a time, and it places the clear write on the exact edge where a pending change lands, to reach the same-cycle case.

// File: rtl/gpio_cn_pkg.sv
package gpio_cn_pkg;
   localparam int unsigned SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_DIR  = 3'd0,
      SEL_LAT  = 3'd1,
      SEL_ANA  = 3'd2,
      SEL_CNE  = 3'd3,
      SEL_PUE  = 3'd4,
      SEL_PIN  = 3'd5,
      SEL_FLG  = 3'd6,
      SEL_RSV  = 3'd7
   } reg_sel_e;
endpackage

// File: rtl/gpio_cn_sync.sv
module gpio_cn_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_cn_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_cn_regs.sv
module gpio_cn_regs
   import gpio_cn_pkg::*;
#(
   parameter int unsigned NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SEL_W-1:0] addr,
   input  logic [NPINS-1:0] wdata,
   input  logic [NPINS-1:0] pin_sync,
   input  logic             flag,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] lat_q,
   output logic [NPINS-1:0] ana_q,
   output logic [NPINS-1:0] cne_q,
   output logic [NPINS-1:0] pue_q,
   output logic [NPINS-1:0] view_q,
   output logic             clr_req,
   output logic [NPINS-1:0] rdata
);
   reg_sel_e sel;
   assign sel = reg_sel_e'(addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '1;
         lat_q <= '0;
         ana_q <= '0;
         cne_q <= '0;
         pue_q <= '0;
      end else if (we) begin
         case (sel)
            SEL_DIR: dir_q <= wdata;
            SEL_LAT: lat_q <= wdata;
            SEL_ANA: ana_q <= wdata;
            SEL_CNE: cne_q <= wdata;
            SEL_PUE: pue_q <= wdata;
            default: ;
         endcase
      end
   end

   // Registered pin view: gives the one-cycle read lag after writes.
   always_ff @(posedge clk) begin
      if (!rst_n) view_q <= '0;
      else        view_q <= ~ana_q & ((dir_q & pin_sync) | (~dir_q & lat_q));
   end

   assign clr_req = we && (sel == SEL_FLG) && wdata[0];

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_DIR: rdata = dir_q;
         SEL_LAT: rdata = lat_q;
         SEL_ANA: rdata = ana_q;
         SEL_CNE: rdata = cne_q;
         SEL_PUE: rdata = pue_q;
         SEL_PIN: rdata = view_q;
         SEL_FLG: rdata[0] = flag;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_cn_detect.sv
module gpio_cn_detect #(
   parameter int unsigned NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_sync,
   input  logic [NPINS-1:0] cne,
   input  logic [NPINS-1:0] ana,
   input  logic             clr_req,
   output logic             change_any,
   output logic             flag
);
   logic [NPINS-1:0] prev_q;
   logic [NPINS-1:0] hit;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_sync;
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign hit[i] = cne[i] & ~ana[i] & (pin_sync[i] ^ prev_q[i]);
   end

   assign change_any = |hit;

   always_ff @(posedge clk) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= (flag & ~clr_req) | change_any;
   end
endmodule

// File: rtl/gpio_cn_port.sv
module gpio_cn_port
   import gpio_cn_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic [SEL_W-1:0] bus_addr,
   input  logic [NPINS-1:0] bus_wdata,
   output logic [NPINS-1:0] bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic [NPINS-1:0] pullup_en,
   output logic             irq
);
   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("gpio_cn_port: NPINS must be within 1..32");
   end

   logic [NPINS-1:0] pin_sync;
   logic [NPINS-1:0] dir_q, lat_q, ana_q, cne_q, pue_q, view_q;
   logic             clr_req, change_any, flag;

   gpio_cn_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
   );

   gpio_cn_regs #(.NPINS(NPINS)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .pin_sync(pin_sync), .flag(flag),
      .dir_q(dir_q), .lat_q(lat_q), .ana_q(ana_q), .cne_q(cne_q),
      .pue_q(pue_q), .view_q(view_q), .clr_req(clr_req), .rdata(bus_rdata)
   );

   gpio_cn_detect #(.NPINS(NPINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .cne(cne_q),
      .ana(ana_q), .clr_req(clr_req), .change_any(change_any), .flag(flag)
   );

   assign pin_out   = lat_q;
   assign pin_oe    = ~dir_q;
   assign pullup_en = pue_q & dir_q;
   assign irq       = flag;
endmodule

// File: rtl/gpio_cn_port_chk.sv
module gpio_cn_port_chk #(
   parameter int unsigned NPINS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] pin_oe,
   input logic [NPINS-1:0] pullup_en,
   input logic             irq,
   input logic [NPINS-1:0] dir_q,
   input logic [NPINS-1:0] ana_q,
   input logic [NPINS-1:0] view_q,
   input logic [NPINS-1:0] pin_sync,
   input logic             clr_req,
   input logic             change_any
);
   // R1: registers hold their reset values in the first cycle after reset.
   p_reset_inputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dir_q == '1) && (pin_oe == '0) && !irq);

   // R4: the registered pin view never shows a 1 on an analog pin
   // (the mask must be stable for the view to have settled).
   p_analog_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(ana_q) |-> ((view_q & ana_q) == '0));

   // R5: no pull-up on a driven pin.
   p_pullup_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pullup_en & pin_oe) == '0);

   // R6: the flag rises only after a synchronized pin moved.
   p_rise_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(pin_sync) != $past(pin_sync, 2)));

   // R7: the flag stays up unless a clear is requested.
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_req) |=> irq);

   // R9: a clear that coincides with a change keeps the flag set.
   p_clear_race_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && change_any) |=> irq);

   // R7: a clear without a change drops the flag.
   p_clear_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !change_any) |=> !irq);
endmodule

bind gpio_cn_port gpio_cn_port_chk #(.NPINS(NPINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .pin_oe(pin_oe), .pullup_en(pullup_en),
   .irq(irq), .dir_q(dir_q), .ana_q(ana_q), .view_q(view_q),
   .pin_sync(pin_sync), .clr_req(clr_req), .change_any(change_any)
);

// File: tb/gpio_cn_port_tb_top.sv
module gpio_cn_port_tb_top;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_we = 1'b0;
   logic [2:0]   bus_addr = '0;
   logic [N-1:0] bus_wdata = '0;
   logic [N-1:0] bus_rdata;
   logic [N-1:0] pin_in = 8'h03;
   logic [N-1:0] pin_out, pin_oe, pullup_en;
   logic         irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_cn_port #(.NPINS(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .pullup_en(pullup_en), .irq(irq)
   );

   // Scoreboard item: which output to compare, expected value, label.
   typedef struct {
      int          kind;   // 0 rdata, 1 irq, 2 pullup_en, 3 pin_oe, 4 pin_out
      logic [N-1:0] exp;
      string       tag;
   } item_t;

   item_t exp_q[$];

   // Driver tasks; all are entered and left on a falling edge.
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic expect_out(input int k, input logic [2:0] a,
                             input logic [N-1:0] e, input string tag);
      item_t it;
      bus_addr = a;
      it.kind = k; it.exp = e; it.tag = tag;
      exp_q.push_back(it);
      @(negedge clk);
   endtask

   // Monitor: compares queued expectations 1 ns after each falling edge.
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (exp_q.size() > 0) begin
            item_t it;
            logic [N-1:0] act;
            it = exp_q.pop_front();
            case (it.kind)
               0: act = bus_rdata;
               1: act = {{(N-1){1'b0}}, irq};
               2: act = pullup_en;
               3: act = pin_oe;
               default: act = pin_out;
            endcase
            n_chk++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(1);
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      expect_out(0, 3'd0, 8'hFF, "R1 dir");
      expect_out(0, 3'd1, 8'h00, "R1 lat");
      expect_out(0, 3'd2, 8'h00, "R1 ana");
      expect_out(0, 3'd3, 8'h00, "R1 cne");
      expect_out(0, 3'd4, 8'h00, "R1 pue");
      expect_out(0, 3'd6, 8'h00, "R1 flag");
      expect_out(1, 3'd0, 8'h00, "R1 irq");
      expect_out(3, 3'd0, 8'h00, "R1 oe");
      // pin_in=03 synchronized long ago; all inputs
      expect_out(0, 3'd5, 8'h03, "R2 all-input read");

      // R2 mixed direction
      wr(3'd0, 8'h0F);
      wr(3'd1, 8'hA5);
      idle(1);
      expect_out(3, 3'd0, 8'hF0, "R2 oe");
      expect_out(4, 3'd0, 8'hA5, "R2 pin_out");
      expect_out(0, 3'd5, 8'hA3, "R2 mixed read");

      // R3 read lag after latch write
      wr(3'd1, 8'h5A);
      expect_out(0, 3'd5, 8'hA3, "R3 old value next cycle");
      expect_out(0, 3'd5, 8'h53, "R3 new value after lag");
      // R3 lag after direction write (all inputs again)
      wr(3'd0, 8'hFF);
      expect_out(0, 3'd5, 8'h53, "R3 old after dir change");
      expect_out(0, 3'd5, 8'h03, "R3 new after dir change");
      // R3 external level latency: three edges
      pin_in = 8'h0C;
      idle(2);
      expect_out(0, 3'd5, 8'h03, "R3 ext not yet");
      expect_out(0, 3'd5, 8'h0C, "R3 ext visible");

      // R4 analog mask
      wr(3'd2, 8'h0C);
      idle(1);
      expect_out(0, 3'd5, 8'h00, "R4 analog pins read zero");
      wr(3'd2, 8'h04);
      idle(1);
      expect_out(0, 3'd5, 8'h08, "R4 partial mask");
      wr(3'd2, 8'h00);

      // R5 pull-ups
      wr(3'd0, 8'h0F);
      wr(3'd4, 8'hFF);
      expect_out(2, 3'd0, 8'h0F, "R5 pullups only on inputs");
      wr(3'd0, 8'hFF);
      expect_out(2, 3'd0, 8'hFF, "R5 all inputs pulled");
      wr(3'd4, 8'h00);

      // R6 change detection on enabled pin 0
      wr(3'd3, 8'h01);
      idle(3);
      expect_out(1, 3'd0, 8'h00, "R6 quiet before change");
      pin_in = 8'h0D;
      idle(2);
      expect_out(1, 3'd0, 8'h00, "R6 not before third edge");
      expect_out(1, 3'd0, 8'h01, "R6 irq raised");
      // R7 sticky
      pin_in = 8'h0D;
      idle(5);
      expect_out(1, 3'd0, 8'h01, "R7 still set");
      expect_out(0, 3'd6, 8'h01, "R7 flag readback");
      wr(3'd6, 8'h00);
      expect_out(1, 3'd0, 8'h01, "R7 zero write keeps flag");
      wr(3'd6, 8'h01);
      expect_out(1, 3'd0, 8'h00, "R7 cleared");

      // R8 disabled pin 1 toggles
      pin_in = 8'h0F;
      idle(5);
      expect_out(1, 3'd0, 8'h00, "R8 disabled pin ignored");
      // R8 analog pin 2 with enable
      wr(3'd3, 8'h04);
      wr(3'd2, 8'h04);
      idle(3);
      pin_in = 8'h0B;
      idle(5);
      expect_out(1, 3'd0, 8'h00, "R8 analog pin ignored");
      wr(3'd2, 8'h00);
      idle(3);

      // R9 clear racing a change on enabled pin 0
      wr(3'd3, 8'h01);
      pin_in = 8'h0A;
      idle(5);
      expect_out(1, 3'd0, 8'h01, "R9 setup flag");
      pin_in = 8'h0B;
      idle(2);
      wr(3'd6, 8'h01);
      expect_out(1, 3'd0, 8'h01, "R9 change wins over clear");
      wr(3'd6, 8'h01);
      expect_out(1, 3'd0, 8'h00, "R9 later clear works");

      idle(2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule